// File: doc/BRIEF.md
# SAR ADC Digital Serial Sequencer

This block holds the digital side of a 12-bit successive-approximation converter that has a three-wire serial port. The port signals are an active-low chip select, which also acts as shutdown, an externally supplied data clock, and a serial data output that can be tri-stated. An abstracted analog model sits outside the block. It holds the sampled input and compares it against the trial code that the block drives on `dac_code_o`. The model returns a single comparator bit on `cmp_i`.

The block runs on a fast system clock. It detects edges on `cs_ni` and `dclk_i` one system cycle after they arrive, and both inputs are assumed to be synchronous to `clk_i` already.

A frame proceeds as follows:

1. Chip select falls and the frame opens in the acquisition phase.
2. On the first data-clock falling edge the output driver turns on with a null bit, and conversion begins.
3. Each later rising edge resolves one bit, MSB first.
4. The falling edge that follows each decision shifts that bit out.
5. Once the LSB has gone out, the word is sent again LSB-side first, and the output then floats.

Releasing chip select at any time ends the frame at once. This lets a host stop early and accept a result with fewer bits.

Top module: `sar_seq_top`

## Requirements
- R1: After reset `dout_oe_o`, `sample_o`, `convert_o` and `done_o` are 0 and `result_o` is 0.
- R2: A falling edge of `cs_ni` starts a frame. `sample_o` goes to 1, `done_o` and `result_o` clear to 0, and the output stays disabled.
- R3: On the first `dclk_i` falling edge after chip select falls, `dout_oe_o` goes to 1 with `dout_o` = 0 (the null bit). In the same step `sample_o` drops and `convert_o` rises.
- R4: `dac_code_o` is offset binary. The first trial is 0x800. Each rising edge that comes after the first falling edge decides one bit, MSB first: the trial bit is kept when `cmp_i` = 1 and cleared when `cmp_i` = 0. The next trial is the decided bits plus the next lower bit, so the step halves each time (0x400, 0x200, ...).
- R5: Falling edges 2 to 13 of a frame drive bits B11 down to B0 of the two's-complement result. The result is the offset-binary code with bit 11 inverted.
- R6: After the twelfth decision, `done_o` = 1 and `convert_o` = 0. `result_o` then holds the two's-complement word: 0x800 for all comparator results 0, 0x7FF for all comparator results 1, and 0x000 at mid-scale.
- R7: While chip select stays low, falling edges 14 to 24 drive B1 up to B11 again. From falling edge 25 on, the output is disabled, and it stays disabled until chip select rises and falls again.
- R8: When `cs_ni` rises at any point, the output is disabled, `sample_o` and `convert_o` go to 0, and no further bits are decided. If fewer than 12 bits had been resolved, `done_o` stays 0.
- R9: A frame aborted by chip select does not disturb the next frame. The next falling edge of chip select gives a complete and correct conversion.
- R10: Data-clock edges while chip select is high have no effect: the output stays disabled, and `dac_code_o` and `done_o` do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low; when high, the block is in the static (shutdown) state |
| dclk_i | input | 1 | Serial data clock, synchronous to clk_i |
| cmp_i | input | 1 | Comparator result: 1 means the held input is at or above the trial level |
| dout_o | output | 1 | Serial data bit |
| dout_oe_o | output | 1 | Output driver enable; 0 means high impedance |
| dac_code_o | output | 12 | Offset-binary trial code for the capacitive DAC |
| sample_o | output | 1 | Acquisition phase active |
| convert_o | output | 1 | Conversion phase active |
| done_o | output | 1 | All 12 bits resolved in the current frame |
| result_o | output | 12 | Two's-complement result, valid when done_o is 1 |

## Verification
A wrong bit pointer or a bad decided-bit register shows up on `dac_code_o` before the very next rising edge, because every trial code is compared against an independent halving search. A wrong falling-edge count shows up as a misplaced null bit, a stream shifted by one, a replay in the wrong order, or an output that does not float after edge 24. Each of these appears within one data-clock period of the fault. Abort handling is observed on the enable and phase outputs a few system cycles after chip select rises, and the frame after the abort is checked in full.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ACQ,
    PH_CONV,
    PH_HOLD
  } phase_e;
endpackage

// File: rtl/sar_edge_det.sv
module sar_edge_det #(
  parameter bit RISING  = 1'b1,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= sig_i;
  end

  generate
    if (RISING) begin : g_rise
      assign edge_o = sig_i & ~prev_q;
    end else begin : g_fall
      assign edge_o = ~sig_i & prev_q;
    end
  endgenerate
endmodule

// File: rtl/sar_core.sv
module sar_core #(
  parameter int NBITS = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             decide_i,
  input  logic             cmp_i,
  output logic [NBITS-1:0] sar_o,
  output logic [NBITS-1:0] trial_o,
  output logic             full_o
);
  localparam int CW = $clog2(NBITS + 1);
  localparam logic [NBITS-1:0] MSB_ONLY = {1'b1, {(NBITS-1){1'b0}}};

  logic [NBITS-1:0] sar_q;
  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    ptr;

  assign full_o = (cnt_q == CW'(NBITS));
  assign ptr    = CW'(NBITS - 1) - cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sar_q <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      sar_q <= '0;
      cnt_q <= '0;
    end else if (decide_i && !full_o) begin
      sar_q[ptr] <= cmp_i;
      cnt_q      <= cnt_q + 1'b1;
    end
  end

  assign sar_o   = sar_q;
  assign trial_o = full_o ? sar_q : (sar_q | (MSB_ONLY >> (CW'(NBITS - 1) - ptr)));

  // R4: a cleared register always presents the mid-scale trial first
  p_first_trial_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clear_i) |-> (trial_o == MSB_ONLY));

  p_count_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(NBITS));
endmodule

// File: rtl/sar_frame_ctl.sv
module sar_frame_ctl
  import sar_seq_pkg::*;
#(
  parameter int NBITS = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_high_i,
  input  logic             cs_fall_i,
  input  logic             dclk_rise_i,
  input  logic             dclk_fall_i,
  input  logic             full_i,
  input  logic [NBITS-1:0] word_i,
  output logic             clear_o,
  output logic             decide_o,
  output logic             sample_o,
  output logic             convert_o,
  output logic             dout_o,
  output logic             dout_oe_o,
  output logic             done_o
);
  localparam int FMAX = 2 * NBITS + 1;
  localparam int FW   = $clog2(FMAX + 1);
  localparam int IW   = $clog2(NBITS);

  phase_e        phase_q;
  logic [FW-1:0] fcnt_q, fcnt_n;
  logic          oe_q, dout_q, done_q;
  logic          nxt_oe, nxt_bit;
  logic [IW-1:0] idx;

  assign clear_o  = cs_fall_i;
  assign decide_o = (phase_q == PH_CONV) && dclk_rise_i && !full_i && !cs_high_i;
  assign fcnt_n   = (fcnt_q == FW'(FMAX)) ? fcnt_q : fcnt_q + 1'b1;

  // select the bit shown after the next falling edge
  always_comb begin
    nxt_oe  = 1'b0;
    nxt_bit = 1'b0;
    idx     = '0;
    if (fcnt_n == FW'(1)) begin
      nxt_oe = 1'b1;
    end else if (fcnt_n <= FW'(NBITS + 1)) begin
      nxt_oe  = 1'b1;
      idx     = IW'(NBITS + 1 - int'(fcnt_n));
      nxt_bit = word_i[idx];
    end else if (fcnt_n <= FW'(2 * NBITS)) begin
      nxt_oe  = 1'b1;
      idx     = IW'(int'(fcnt_n) - NBITS - 1);
      nxt_bit = word_i[idx];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      fcnt_q  <= '0;
      oe_q    <= 1'b0;
      dout_q  <= 1'b0;
      done_q  <= 1'b0;
    end else if (cs_high_i) begin
      phase_q <= PH_IDLE;
      oe_q    <= 1'b0;
      dout_q  <= 1'b0;
    end else if (cs_fall_i) begin
      phase_q <= PH_ACQ;
      fcnt_q  <= '0;
      oe_q    <= 1'b0;
      dout_q  <= 1'b0;
      done_q  <= 1'b0;
    end else if (phase_q != PH_IDLE) begin
      if (dclk_fall_i) begin
        fcnt_q <= fcnt_n;
        oe_q   <= nxt_oe;
        dout_q <= nxt_bit;
        if (phase_q == PH_ACQ) phase_q <= PH_CONV;
      end else if (phase_q == PH_CONV && full_i) begin
        phase_q <= PH_HOLD;
        done_q  <= 1'b1;
      end
    end
  end

  assign sample_o  = (phase_q == PH_ACQ);
  assign convert_o = (phase_q == PH_CONV);
  assign dout_o    = dout_q;
  assign dout_oe_o = oe_q;
  assign done_o    = done_q;

  p_hiz_deselect_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_high_i |=> !dout_oe_o);

  p_null_lead_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dout_oe_o) |-> !dout_o);

  p_conv_after_acq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(convert_o) |-> $past(sample_o));

  p_done_selected_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(!cs_high_i && full_i));
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top #(
  parameter int NBITS = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             dclk_i,
  input  logic             cmp_i,
  output logic             dout_o,
  output logic             dout_oe_o,
  output logic [NBITS-1:0] dac_code_o,
  output logic             sample_o,
  output logic             convert_o,
  output logic             done_o,
  output logic [NBITS-1:0] result_o
);
  localparam logic [NBITS-1:0] SIGN = {1'b1, {(NBITS-1){1'b0}}};

  logic cs_fall, dclk_rise, dclk_fall;
  logic clear, decide, full;
  logic [NBITS-1:0] sar, word;

  sar_edge_det #(.RISING(1'b0), .RST_VAL(1'b1)) i_cs_fall (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(cs_ni), .edge_o(cs_fall));
  sar_edge_det #(.RISING(1'b1), .RST_VAL(1'b0)) i_dclk_rise (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(dclk_i), .edge_o(dclk_rise));
  sar_edge_det #(.RISING(1'b0), .RST_VAL(1'b0)) i_dclk_fall (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(dclk_i), .edge_o(dclk_fall));

  sar_core #(.NBITS(NBITS)) i_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear), .decide_i(decide),
    .cmp_i(cmp_i), .sar_o(sar), .trial_o(dac_code_o), .full_o(full));

  assign word = sar ^ SIGN;

  sar_frame_ctl #(.NBITS(NBITS)) i_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_high_i(cs_ni), .cs_fall_i(cs_fall),
    .dclk_rise_i(dclk_rise), .dclk_fall_i(dclk_fall), .full_i(full),
    .word_i(word), .clear_o(clear), .decide_o(decide), .sample_o(sample_o),
    .convert_o(convert_o), .dout_o(dout_o), .dout_oe_o(dout_oe_o),
    .done_o(done_o));

  assign result_o = done_o ? word : '0;

  p_result_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(done_o)) |-> $stable(result_o));

  p_idle_dclk_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cs_ni) && cs_ni && !$past(clear)) |-> $stable(dac_code_o));
endmodule

// File: tb/test_sar_seq_top.sv
module test_sar_seq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        dclk = 1'b0;
  logic        cmp = 1'b0;
  logic        dout, dout_oe, sample, convert, done;
  logic [11:0] dac_code, result;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sar_seq_top i_sar_seq_top (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .dclk_i(dclk), .cmp_i(cmp),
    .dout_o(dout), .dout_oe_o(dout_oe), .dac_code_o(dac_code),
    .sample_o(sample), .convert_o(convert), .done_o(done), .result_o(result));

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int line_val();
    return dout_oe ? int'(dout) : 2;  // 2 = high impedance
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  // one frame of nclk data-clock periods against an input held at vin (offset binary)
  task automatic frame(input logic [11:0] vin, input int nclk);
    logic [11:0] tc;
    int exp_bit;
    logic [11:0] trial;
    tc = vin ^ 12'h800;
    cs_n = 1'b0;
    ticks(3);
    check("R2", "sample after cs fall", int'(sample), 1);
    check("R2", "done cleared", int'(done), 0);
    check("R2", "result cleared", int'(result), 0);
    check("R2", "line floating", line_val(), 2);
    for (int i = 1; i <= nclk; i++) begin
      cmp = (vin >= dac_code);
      if (i >= 2 && i <= 13) begin
        trial = (vin & ~((12'h1 << (14 - i)) - 12'h1)) | (12'h1 << (13 - i));
        check("R4", $sformatf("trial before rise %0d", i), int'(dac_code), int'(trial));
      end
      dclk = 1'b1;
      ticks(3);
      dclk = 1'b0;
      ticks(3);
      if (i == 1) exp_bit = 0;
      else if (i <= 13) exp_bit = int'(tc[13 - i]);
      else if (i <= 24) exp_bit = int'(tc[i - 13]);
      else exp_bit = 2;
      if (i <= 13) check(i == 1 ? "R3" : "R5", $sformatf("line after fall %0d", i), line_val(), exp_bit);
      else         check("R7", $sformatf("line after fall %0d", i), line_val(), exp_bit);
      if (i == 1) begin
        check("R3", "sample off", int'(sample), 0);
        check("R3", "convert on", int'(convert), 1);
      end
      if (i == 13) begin
        check("R6", "done", int'(done), 1);
        check("R6", "convert off", int'(convert), 0);
        check("R6", "result", int'(result), int'(tc));
      end
    end
    cs_n = 1'b1;
    ticks(3);
    check("R8", "line floats after cs rise", line_val(), 2);
    check("R8", "phases idle", int'({sample, convert}), 0);
    if (nclk < 13) check("R8", "done stays low on abort", int'(done), 0);
  endtask

  task automatic test_reset();
    check("R1", "oe", int'(dout_oe), 0);
    check("R1", "sample/convert", int'({sample, convert}), 0);
    check("R1", "done", int'(done), 0);
    check("R1", "result", int'(result), 0);
  endtask

  task automatic test_idle_clocks();
    logic [11:0] dac_before;
    logic done_before;
    dac_before = dac_code;
    done_before = done;
    for (int k = 0; k < 4; k++) begin
      cmp = ~cmp;
      dclk = 1'b1; ticks(3);
      dclk = 1'b0; ticks(3);
      check("R10", "line floats while deselected", line_val(), 2);
    end
    check("R10", "dac code unchanged", int'(dac_code), int'(dac_before));
    check("R10", "done unchanged", int'(done), int'(done_before));
  endtask

  task automatic test_abort_then_full();
    frame(12'h3C7, 5);
    ticks(2);
    frame(12'h5A1, 16);
    check("R9", "clean frame after abort", int'(result), int'(12'h5A1 ^ 12'h800));
  endtask

  initial begin
    ticks(3);
    test_reset();
    rst_n = 1'b1;
    ticks(3);
    test_reset();
    frame(12'h000, 16);   // negative full scale
    frame(12'hFFF, 16);   // positive full scale
    frame(12'h800, 16);   // mid-scale
    frame(12'hA5C, 28);   // replay and float
    test_idle_clocks();
    test_abort_then_full();
    frame(12'h1F0, 1);    // abort right after null bit
    test_idle_clocks();
    frame(12'h7E3, 16);
    finish_run();
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule